// File: doc/BRIEF.md
# Shared-Bus Multicycle Processor Datapath

This block is the datapath half of a multicycle 32-bit processor in which every transfer between units uses a single shared bus. The units are an instruction register, two ALU operand latches, a memory address latch, an immediate/jump-target former and a 33-slot register file. Slot 32 of the register file holds the program counter and slot 31 the link register. In any cycle, an external sequencer enables at most one bus source and any number of loads. A sequence of such cycles carries out one instruction: fetch, operand reads, ALU work, memory access and write-back.

The block reports the current opcode and a flag that is set when operand latch A holds zero. It also drives a simple memory handshake: an enable, a write select, an address taken from the address latch, and write data taken from the bus. Wait states are handled by the sequencer, which holds the memory source enabled until the data is ready. The datapath itself has no sequencing state.

Top module: `sbus_datapath`

## Requirements
- R1: After reset, the instruction register, operand latches A and B, the address latch and every register slot hold zero. Reading any slot onto the bus gives 0, `opcode` is 0 and `a_zero` is 1.
- R2: When no source enable is high, `bus_data` is 0.
- R3: When exactly one source enable is high, `bus_data` equals that source: the selected register slot (`drv_reg`), the ALU result (`drv_alu`), the immediate former (`drv_imm`) or `mem_rdata` (`drv_mem`).
- R4: `reg_sel` chooses the register slot: 0 selects IR[25:21], 1 selects IR[20:16], 2 selects IR[15:11], 3 selects slot 32 (program counter) and 4 selects slot 31 (link). Codes 5, 6 and 7 address slot 0.
- R5: Slot 0 always reads as 0, even after a write to it.
- R6: `ext_sel` sets the immediate former output, with imm = IR[15:0]. Code 0 gives imm sign-extended to 32 bits. Code 1 gives imm zero-extended. Code 2 gives imm shifted left by 2 and then sign-extended ({14 copies of imm[15], imm, 2'b00}). Code 3 gives the jump target {A[31:28], B[25:0], 2'b00}.
- R7: `alu_op` picks the ALU result from A and B: 0 gives A+B, 1 gives A−B, 2 gives A AND B and 3 gives A OR B (all modulo 2^32).
- R8: At a rising clock edge, `ld_ir`, `ld_a`, `ld_b` and `ld_ma` each capture `bus_data` into their latch. A latch whose load is low keeps its value.
- R9: `opcode` is IR[31:26]. `a_zero` is 1 exactly when A is zero and follows A in the same cycle it changes.
- R10: `mem_en` is high when `drv_mem` or `mem_wr` is high. `mem_we` equals `mem_wr` (1 means write). `mem_addr` is the address latch and `bus_data` is the write data.
- R11: At a rising edge with `reg_wr` high, `bus_data` is written into the slot chosen by `reg_sel`. With `reg_wr` low, no slot changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_reg | input | 1 | Register file drives the bus |
| drv_alu | input | 1 | ALU result drives the bus |
| drv_imm | input | 1 | Immediate former drives the bus |
| drv_mem | input | 1 | Memory read data drives the bus |
| ld_ir | input | 1 | Load instruction register from bus |
| ld_a | input | 1 | Load operand latch A from bus |
| ld_b | input | 1 | Load operand latch B from bus |
| ld_ma | input | 1 | Load memory address latch from bus |
| reg_wr | input | 1 | Write bus into selected register slot |
| mem_wr | input | 1 | Request memory write of bus data |
| reg_sel | input | 3 | Register slot select code |
| ext_sel | input | 2 | Immediate former mode |
| alu_op | input | 2 | ALU function code |
| mem_rdata | input | 32 | Read data from memory |
| bus_data | output | 32 | Shared bus value, also memory write data |
| mem_addr | output | 32 | Memory address latch |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write select |
| opcode | output | 6 | IR[31:26] |
| a_zero | output | 1 | Latch A equals zero |

## Verification
The checks assume that the sequencer never enables two bus sources in the same cycle, because the bus has no defined value when sources overlap. They also assume that `mem_rdata` is meaningful only while `drv_mem` is high. The stimulus enables exactly one source, or none, in every cycle. It reads memory only through a bench-side memory model that is indexed by the address latch. It holds the read enable across several cycles to stand in for wait states before the load. Every cycle, a behavioural model of the latches, slots and memory is compared against the outputs.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [2:0] {
        RSEL_RS   = 3'd0,
        RSEL_RT   = 3'd1,
        RSEL_RD   = 3'd2,
        RSEL_PC   = 3'd3,
        RSEL_LINK = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        XSEL_SIGN     = 2'd0,
        XSEL_ZERO     = 2'd1,
        XSEL_SIGN_SH2 = 2'd2,
        XSEL_JUMP     = 2'd3
    } ext_sel_e;

    typedef enum logic [1:0] {
        AOP_ADD = 2'd0,
        AOP_SUB = 2'd1,
        AOP_AND = 2'd2,
        AOP_OR  = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_ALU = 2'd1,
        SRC_IMM = 2'd2,
        SRC_MEM = 2'd3
    } bus_src_e;

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
    parameter int DW     = 32,
    parameter int NSLOT  = 33,
    localparam int AW    = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] slot_q [NSLOT];

    // slot 0 is a hard zero
    assign slot_q[0] = '0;

    for (genvar g = 1; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (we && (int'(addr) == g)) begin
                slot_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (int'(addr) == i) begin
                rdata = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [1:0]    op,
    output logic [DW-1:0] res
);

    alu_op_e op_e;
    assign op_e = alu_op_e'(op);

    always_comb begin
        unique case (op_e)
            AOP_ADD: res = opa + opb;
            AOP_SUB: res = opa - opb;
            AOP_AND: res = opa & opb;
            AOP_OR:  res = opa | opb;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/sbus_immext.sv
module sbus_immext
    import sbus_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IMM_W = 16,
    parameter int JMP_W = 26,
    localparam int TOP_W = DW - JMP_W - 2
) (
    input  logic [DW-1:0] ir,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [1:0]    sel,
    output logic [DW-1:0] res
);

    logic [IMM_W-1:0] imm;
    ext_sel_e         sel_e;

    assign imm   = ir[IMM_W-1:0];
    assign sel_e = ext_sel_e'(sel);

    always_comb begin
        unique case (sel_e)
            XSEL_SIGN:     res = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
            XSEL_ZERO:     res = {{(DW-IMM_W){1'b0}}, imm};
            XSEL_SIGN_SH2: res = {{(DW-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
            XSEL_JUMP:     res = {opa[DW-1 -: TOP_W], opb[JMP_W-1:0], 2'b00};
            default:       res = '0;
        endcase
    end

endmodule

// File: rtl/sbus_busmux.sv
module sbus_busmux #(
    parameter int DW   = 32,
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0]         en,
    input  logic [NSRC-1:0][DW-1:0] src,
    output logic [DW-1:0]           bus
);

    logic [NSRC-1:0][DW-1:0] gated;

    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign gated[g] = src[g] & {DW{en[g]}};
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++) begin
            bus = bus | gated[i];
        end
    end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NSLOT  = 33,
    parameter int FLD_W  = 5,
    parameter int OP_W   = 6,
    parameter int IMM_W  = 16,
    parameter int JMP_W  = 26,
    localparam int AW    = $clog2(NSLOT),
    localparam int NSRC  = 4,
    localparam int RS_LO = DW - OP_W - FLD_W,
    localparam int RT_LO = RS_LO - FLD_W,
    localparam int RD_LO = RT_LO - FLD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drv_reg,
    input  logic          drv_alu,
    input  logic          drv_imm,
    input  logic          drv_mem,
    input  logic          ld_ir,
    input  logic          ld_a,
    input  logic          ld_b,
    input  logic          ld_ma,
    input  logic          reg_wr,
    input  logic          mem_wr,
    input  logic [2:0]    reg_sel,
    input  logic [1:0]    ext_sel,
    input  logic [1:0]    alu_op,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] bus_data,
    output logic [DW-1:0] mem_addr,
    output logic          mem_en,
    output logic          mem_we,
    output logic [OP_W-1:0] opcode,
    output logic          a_zero
);

    logic [DW-1:0] ir_q, a_q, b_q, ma_q;
    logic [DW-1:0] rf_rdata, alu_res, imm_res;
    logic [AW-1:0] rf_addr;
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0][DW-1:0] src_val;
    reg_sel_e sel_e;

    // register slot address selection
    assign sel_e = reg_sel_e'(reg_sel);
    always_comb begin
        unique case (sel_e)
            RSEL_RS:   rf_addr = AW'(ir_q[RS_LO +: FLD_W]);
            RSEL_RT:   rf_addr = AW'(ir_q[RT_LO +: FLD_W]);
            RSEL_RD:   rf_addr = AW'(ir_q[RD_LO +: FLD_W]);
            RSEL_PC:   rf_addr = AW'(NSLOT - 1);
            RSEL_LINK: rf_addr = AW'(NSLOT - 2);
            default:   rf_addr = '0;
        endcase
    end

    sbus_regfile #(.DW(DW), .NSLOT(NSLOT)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_wr),
        .addr  (rf_addr),
        .wdata (bus_data),
        .rdata (rf_rdata)
    );

    sbus_alu #(.DW(DW)) u_alu (
        .opa (a_q),
        .opb (b_q),
        .op  (alu_op),
        .res (alu_res)
    );

    sbus_immext #(.DW(DW), .IMM_W(IMM_W), .JMP_W(JMP_W)) u_imm (
        .ir  (ir_q),
        .opa (a_q),
        .opb (b_q),
        .sel (ext_sel),
        .res (imm_res)
    );

    // source table indexed by bus_src_e
    always_comb begin
        src_en                = '0;
        src_en[int'(SRC_REG)] = drv_reg;
        src_en[int'(SRC_ALU)] = drv_alu;
        src_en[int'(SRC_IMM)] = drv_imm;
        src_en[int'(SRC_MEM)] = drv_mem;
        src_val                = '0;
        src_val[int'(SRC_REG)] = rf_rdata;
        src_val[int'(SRC_ALU)] = alu_res;
        src_val[int'(SRC_IMM)] = imm_res;
        src_val[int'(SRC_MEM)] = mem_rdata;
    end

    sbus_busmux #(.DW(DW), .NSRC(NSRC)) u_bus (
        .en  (src_en),
        .src (src_val),
        .bus (bus_data)
    );

    // bus-loaded latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
            ma_q <= '0;
        end else begin
            if (ld_ir) ir_q <= bus_data;
            if (ld_a)  a_q  <= bus_data;
            if (ld_b)  b_q  <= bus_data;
            if (ld_ma) ma_q <= bus_data;
        end
    end

    always_comb begin
        opcode   = ir_q[DW-1 -: OP_W];
        a_zero   = (a_q == '0);
        mem_addr = ma_q;
        mem_en   = drv_mem | mem_wr;
        mem_we   = mem_wr;
    end

endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          drv_reg,
    input logic          drv_alu,
    input logic          drv_imm,
    input logic          drv_mem,
    input logic          ld_ir,
    input logic          ld_a,
    input logic          ld_ma,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] bus_data,
    input logic [DW-1:0] mem_addr,
    input logic          mem_en,
    input logic          mem_we,
    input logic [5:0]    opcode,
    input logic          a_zero,
    input logic [AW-1:0] rf_addr
);

    // R3
    drv_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_reg, drv_alu, drv_imm, drv_mem}));

    // R2
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({drv_reg, drv_alu, drv_imm, drv_mem} == 4'b0) |-> (bus_data == '0));

    // R5
    zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_reg && rf_addr == '0) |-> (bus_data == '0));

    // R8
    ma_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ma |=> (mem_addr == $past(bus_data)));

    // R8
    ma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ma |=> $stable(mem_addr));

    // R9
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ir |=> $stable(opcode));

    // R8
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_a |=> $stable(a_zero));

    // R10
    we_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R3
    rd_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_mem && !drv_reg && !drv_alu && !drv_imm) |-> (bus_data == mem_rdata));

endmodule

bind sbus_datapath sbus_datapath_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_reg   (drv_reg),
    .drv_alu   (drv_alu),
    .drv_imm   (drv_imm),
    .drv_mem   (drv_mem),
    .ld_ir     (ld_ir),
    .ld_a      (ld_a),
    .ld_ma     (ld_ma),
    .mem_rdata (mem_rdata),
    .bus_data  (bus_data),
    .mem_addr  (mem_addr),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .opcode    (opcode),
    .a_zero    (a_zero),
    .rf_addr   (rf_addr)
);

// File: tb/sbus_datapath_bench.sv
module sbus_datapath_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drv_reg = 0, drv_alu = 0, drv_imm = 0, drv_mem = 0;
    logic        ld_ir = 0, ld_a = 0, ld_b = 0, ld_ma = 0;
    logic        reg_wr = 0, mem_wr = 0;
    logic [2:0]  reg_sel = 0;
    logic [1:0]  ext_sel = 0, alu_op = 0;
    logic [31:0] mem_rdata, bus_data, mem_addr;
    logic        mem_en, mem_we, a_zero;
    logic [5:0]  opcode;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    sbus_datapath u_sbus_datapath (
        .clk(clk), .rst_n(rst_n),
        .drv_reg(drv_reg), .drv_alu(drv_alu), .drv_imm(drv_imm), .drv_mem(drv_mem),
        .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma),
        .reg_wr(reg_wr), .mem_wr(mem_wr),
        .reg_sel(reg_sel), .ext_sel(ext_sel), .alu_op(alu_op),
        .mem_rdata(mem_rdata), .bus_data(bus_data), .mem_addr(mem_addr),
        .mem_en(mem_en), .mem_we(mem_we), .opcode(opcode), .a_zero(a_zero)
    );

    // memory device model seen by the design
    logic [31:0] mem_arr [64];
    assign mem_rdata = mem_arr[mem_addr[7:2]];
    always @(posedge clk) if (mem_we) mem_arr[mem_addr[7:2]] <= bus_data;

    // behavioural reference state
    logic [31:0] m_rf [33];
    logic [31:0] m_mem [64];
    logic [31:0] m_ir, m_a, m_b, m_ma;

    function automatic int slot_of(input logic [2:0] s);
        case (s)
            3'd0: return int'(m_ir[25:21]);
            3'd1: return int'(m_ir[20:16]);
            3'd2: return int'(m_ir[15:11]);
            3'd3: return 32;
            3'd4: return 31;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] exp_bus();
        logic [15:0] im;
        im = m_ir[15:0];
        if (drv_reg) begin
            int k;
            k = slot_of(reg_sel);
            return (k == 0) ? 32'd0 : m_rf[k];
        end
        if (drv_alu) begin
            case (alu_op)
                2'd0: return m_a + m_b;
                2'd1: return m_a - m_b;
                2'd2: return m_a & m_b;
                default: return m_a | m_b;
            endcase
        end
        if (drv_imm) begin
            case (ext_sel)
                2'd0: return {{16{im[15]}}, im};
                2'd1: return {16'd0, im};
                2'd2: return {{14{im[15]}}, im, 2'b00};
                default: return {m_a[31:28], m_b[25:0], 2'b00};
            endcase
        end
        if (drv_mem) return m_mem[m_ma[7:2]];
        return 32'd0;
    endfunction

    task automatic step(input logic [3:0] drv, input logic [3:0] ld,
                        input logic rw, input logic mw, input logic [2:0] rs,
                        input logic [1:0] es, input logic [1:0] op, input string tag);
        logic [31:0] eb;
        logic        ok;
        @(negedge clk);
        {drv_reg, drv_alu, drv_imm, drv_mem} = drv;
        {ld_ir, ld_a, ld_b, ld_ma} = ld;
        reg_wr = rw; mem_wr = mw; reg_sel = rs; ext_sel = es; alu_op = op;
        #1;
        eb = exp_bus();
        ok = (bus_data === eb) && (opcode === m_ir[31:26]) && (a_zero === (m_a == 0))
          && (mem_addr === m_ma) && (mem_en === (drv[0] | mw)) && (mem_we === mw);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: bus=%h op=%h az=%b ma=%h en=%b we=%b expected bus=%h op=%h az=%b ma=%h en=%b we=%b",
                     tag, bus_data, opcode, a_zero, mem_addr, mem_en, mem_we,
                     eb, m_ir[31:26], (m_a == 0), m_ma, drv[0] | mw, mw);
        end
        @(posedge clk);
        if (ld[3]) m_ir = eb;
        if (ld[2]) m_a  = eb;
        if (ld[1]) m_b  = eb;
        if (mw) m_mem[m_ma[7:2]] = eb;
        if (ld[0]) m_ma = eb;
        if (rw && slot_of(rs) != 0) m_rf[slot_of(rs)] = eb;
    endtask

    localparam logic [3:0] D_NONE = 4'b0000, D_REG = 4'b1000, D_ALU = 4'b0100,
                           D_IMM = 4'b0010, D_MEM = 4'b0001;
    localparam logic [3:0] L_NONE = 4'b0000, L_IR = 4'b1000, L_A = 4'b0100,
                           L_B = 4'b0010, L_MA = 4'b0001;

    initial begin : watchdog
        #(8 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 64; i++) begin
            mem_arr[i] = 32'h0101_0101 * i + 32'h00F0_0F00;
        end
        mem_arr[0] = {6'h23, 5'd5, 5'd0, 16'h8ABC};
        for (int i = 0; i < 64; i++) m_mem[i] = mem_arr[i];
        for (int i = 0; i < 33; i++) m_rf[i] = 32'd0;
        m_ir = 0; m_a = 0; m_b = 0; m_ma = 0;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        step(D_NONE, L_NONE, 0, 0, 0, 0, 0, "R1 idle after reset");
        step(D_REG,  L_NONE, 0, 0, 3'd0, 0, 0, "R1 slot reads zero");
        step(D_REG,  L_NONE, 0, 0, 3'd3, 0, 0, "R1 pc slot zero");
        step(D_NONE, L_MA,   0, 0, 0, 0, 0, "R2 empty bus into MA");
        // wait states: read held before the load
        step(D_MEM,  L_NONE, 0, 0, 0, 0, 0, "R10 read wait 1");
        step(D_MEM,  L_NONE, 0, 0, 0, 0, 0, "R10 read wait 2");
        step(D_MEM,  L_IR,   0, 0, 0, 0, 0, "R8 IR load from memory");
        step(D_NONE, L_NONE, 0, 0, 0, 0, 0, "R9 opcode after load");
        step(D_IMM,  L_NONE, 1, 0, 3'd0, 2'd0, 0, "R6 sign ext into rs");
        step(D_IMM,  L_NONE, 1, 0, 3'd4, 2'd1, 0, "R6 zero ext into link");
        step(D_IMM,  L_NONE, 1, 0, 3'd3, 2'd2, 0, "R6 shifted ext into pc");
        step(D_IMM,  L_NONE, 1, 0, 3'd1, 2'd1, 0, "R5 write to slot 0");
        step(D_REG,  L_NONE, 0, 0, 3'd1, 0, 0, "R5 slot 0 read");
        for (int s = 5; s < 8; s++)
            step(D_REG, L_NONE, 0, 0, 3'(s), 0, 0, "R4 spare code");
        step(D_REG,  L_NONE, 0, 0, 3'd0, 0, 0, "R4 rs field");
        step(D_REG,  L_NONE, 0, 0, 3'd4, 0, 0, "R4 link slot");
        step(D_REG,  L_NONE, 0, 0, 3'd3, 0, 0, "R4 pc slot");
        step(D_REG,  L_A,    0, 0, 3'd0, 0, 0, "R8 load A");
        step(D_REG,  L_B,    0, 0, 3'd4, 0, 0, "R8 load B");
        step(D_NONE, L_NONE, 0, 0, 0, 0, 0, "R9 a_zero low");
        for (int o = 0; o < 4; o++) begin
            step(D_ALU, L_NONE, 1, 0, 3'd2, 0, 2'(o), "R7 alu into rd");
            step(D_REG, L_NONE, 0, 0, 3'd2, 0, 0, "R11 rd readback");
        end
        step(D_IMM,  L_NONE, 0, 0, 0, 2'd3, 0, "R6 jump target");
        step(D_REG,  L_MA,   0, 0, 3'd3, 0, 0, "R8 MA from pc slot");
        step(D_REG,  L_NONE, 0, 1, 3'd0, 0, 0, "R10 memory write");
        step(D_NONE, L_NONE, 0, 0, 0, 0, 0, "R10 idle after write");
        step(D_MEM,  L_NONE, 0, 0, 0, 0, 0, "R10 read back written word");
        step(D_MEM,  L_B,    0, 0, 0, 0, 0, "R3 memory into B");
        step(D_ALU,  L_NONE, 0, 0, 0, 0, 2'd1, "R3 alu on bus");
        step(D_REG,  L_A,    0, 0, 3'd1, 0, 0, "R9 A from slot 0");
        step(D_NONE, L_NONE, 0, 0, 0, 0, 0, "R9 a_zero high");
        step(D_REG,  L_NONE, 0, 0, 3'd0, 0, 0, "R11 rs kept without write");
        step(D_IMM,  L_NONE, 0, 0, 3'd4, 2'd0, 0, "R11 drive without write");
        step(D_REG,  L_NONE, 0, 0, 3'd4, 0, 0, "R11 link kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule